// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard control for an in-order five-stage integer pipeline: fetch, decode with register read, execute, memory access and writeback. Each cycle it looks at the source register numbers of the instruction in decode and at the destination numbers, write enables and load flags held in the decode/execute and execute/memory pipeline registers. From these it decides three things. The first is where each ALU operand should come from when that instruction reaches execute. The second is whether the front of the pipe must hold for a cycle. The third is whether the instruction just fetched behind a taken branch must be discarded.

Operand selects are worked out one stage early and registered, so they are ready at the start of the execute cycle with no comparator delay in front of the ALU muxes. Only read-after-write dependences are tracked. Reads happen in decode and writes happen in writeback, so the other two dependence kinds cannot arise. The register file is expected to pass a value written in a cycle through to a read in that same cycle. Branches compare one register against zero in decode and the fetch path assumes not-taken, so a taken branch costs exactly one squashed slot.

`stall` freezes the program counter and the fetch/decode register, and turns the decode/execute entry into a bubble. `flush_fetch` clears the fetch/decode register.

Top module: `hzd_unit`

## Requirements
- R1: After reset both operand selects are 2'b00, meaning the operand is taken from the register file.
- R2: If the decode instruction reads a source register s (its use flag is high), s is not zero, no stall is raised, and the decode/execute stage writes s, then in the next cycle that operand's select is 2'b01, meaning the value comes from the execute/memory register.
- R3: If the decode instruction reads a nonzero source s that the execute/memory stage writes (load or not), the decode/execute stage does not write s, and no stall is raised, then in the next cycle that operand's select is 2'b10, meaning the value comes from the memory/writeback register.
- R4: When both later stages write the same source register, the select is 2'b01, so the newer result wins.
- R5: Register 0 is never forwarded. A source or destination of zero yields select 2'b00 and causes no stall.
- R6: A source whose use flag is low, or a stage whose write enable is low, causes neither forwarding nor a stall.
- R7: A load in the decode/execute stage that writes a nonzero register read by the decode instruction raises `stall` in the same cycle. In the following cycle both selects are 2'b00, which is the bubble.
- R8: A branch in decode whose tested register (source 1) is written by the decode/execute stage, or by a load in the execute/memory stage, raises `stall` in the same cycle.
- R9: `br_src_fwd` is 1 in the same cycle exactly when a branch is in decode, its tested register is nonzero and is written by a non-load in the execute/memory stage, and the decode/execute stage does not write it.
- R10: `flush_fetch` is 1 in the same cycle exactly when a branch is in decode, its resolved outcome is taken, and `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_src1 | input | REG_AW | First source register number of the decode instruction |
| dec_use1 | input | 1 | Decode instruction reads its first source |
| dec_src2 | input | REG_AW | Second source register number of the decode instruction |
| dec_use2 | input | 1 | Decode instruction reads its second source |
| dec_branch | input | 1 | Decode instruction is a conditional branch on source 1 |
| dec_br_taken | input | 1 | Outcome of the zero test in decode |
| ex_dst | input | REG_AW | Destination in the decode/execute register |
| ex_wen | input | 1 | Decode/execute entry writes a register |
| ex_load | input | 1 | Decode/execute entry is a load |
| mem_dst | input | REG_AW | Destination in the execute/memory register |
| mem_wen | input | 1 | Execute/memory entry writes a register |
| mem_load | input | 1 | Execute/memory entry is a load |
| stall | output | 1 | Hold PC and fetch/decode register, insert bubble |
| flush_fetch | output | 1 | Discard the fetched instruction behind a taken branch |
| br_src_fwd | output | 1 | Feed the zero test from the execute/memory result |
| alu_sel_a | output | 2 | Select for ALU operand A during execute |
| alu_sel_b | output | 2 | Select for ALU operand B during execute |

## Verification
`stall`, `flush_fetch` and `br_src_fwd` are combinational and are due in the same cycle as the decode-side inputs that cause them. The two ALU selects are due one clock edge later, when the instruction has moved into execute. The bench drives a new input set on each falling edge and checks the combinational outputs one time unit later. At the next falling edge, before it drives the next set, it compares the registered selects with the values predicted from the previous set. Register numbers are drawn from a small range so that matches, register-0 cases and coincident stage matches come up often alongside the directed cases.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_EXMEM   = 2'b01,
        SRC_MEMWB   = 2'b10
    } opnd_src_e;

    typedef struct packed {
        opnd_src_e sel_a;
        opnd_src_e sel_b;
    } fwd_state_t;

endpackage

// File: rtl/hzd_match.sv
module hzd_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              src_used,
    input  logic [REG_AW-1:0] dst,
    input  logic              dst_wen,
    output logic              hit
);
    // register zero is hard-wired, so a write to it never creates a dependence
    always_comb begin
        hit = src_used && dst_wen && (dst != '0) && (src == dst);
    end
endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
    import hzd_pkg::*;
(
    input  logic      hit_newer,
    input  logic      hit_older,
    output opnd_src_e pick
);
    always_comb begin
        if (hit_newer)      pick = SRC_EXMEM;
        else if (hit_older) pick = SRC_MEMWB;
        else                pick = SRC_REGFILE;
    end
endmodule

// File: rtl/hzd_branch_ctl.sv
module hzd_branch_ctl (
    input  logic dec_branch,
    input  logic dec_br_taken,
    input  logic br_hit_ex,
    input  logic br_hit_mem,
    input  logic mem_load,
    input  logic load_use,
    output logic stall,
    output logic flush_fetch,
    output logic br_src_fwd
);
    logic br_wait;

    always_comb begin
        // value still in the ALU, or a load not yet back from memory
        br_wait     = br_hit_ex || (br_hit_mem && mem_load);
        stall       = load_use || br_wait;
        br_src_fwd  = br_hit_mem && !mem_load && !br_hit_ex;
        flush_fetch = dec_branch && dec_br_taken && !stall;
    end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] dec_src1,
    input  logic              dec_use1,
    input  logic [REG_AW-1:0] dec_src2,
    input  logic              dec_use2,
    input  logic              dec_branch,
    input  logic              dec_br_taken,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_wen,
    input  logic              ex_load,
    input  logic [REG_AW-1:0] mem_dst,
    input  logic              mem_wen,
    input  logic              mem_load,
    output logic              stall,
    output logic              flush_fetch,
    output logic              br_src_fwd,
    output logic [1:0]        alu_sel_a,
    output logic [1:0]        alu_sel_b
);
    localparam int NSRC = 2;

    logic [REG_AW-1:0] src_v  [NSRC];
    logic              use_v  [NSRC];
    logic              hit_ex [NSRC];
    logic              hit_mem[NSRC];
    opnd_src_e         pick_v [NSRC];
    logic [NSRC-1:0]   lu_v;
    logic              load_use;
    logic              br_hit_ex;
    logic              br_hit_mem;

    fwd_state_t state_d;
    fwd_state_t state_q;

    always_comb begin
        src_v[0] = dec_src1;
        src_v[1] = dec_src2;
        use_v[0] = dec_use1;
        use_v[1] = dec_use2;
    end

    // one comparator pair and one priority pick per ALU source
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        hzd_match #(.REG_AW(REG_AW)) u_cmp_ex (
            .src     (src_v[i]),
            .src_used(use_v[i]),
            .dst     (ex_dst),
            .dst_wen (ex_wen),
            .hit     (hit_ex[i])
        );
        hzd_match #(.REG_AW(REG_AW)) u_cmp_mem (
            .src     (src_v[i]),
            .src_used(use_v[i]),
            .dst     (mem_dst),
            .dst_wen (mem_wen),
            .hit     (hit_mem[i])
        );
        hzd_fwd_pick u_pick (
            .hit_newer(hit_ex[i]),
            .hit_older(hit_mem[i]),
            .pick     (pick_v[i])
        );
        always_comb lu_v[i] = hit_ex[i] && ex_load;
    end

    always_comb load_use = |lu_v;

    // branch zero test reads source 1 in decode
    hzd_match #(.REG_AW(REG_AW)) u_br_ex (
        .src     (dec_src1),
        .src_used(dec_branch),
        .dst     (ex_dst),
        .dst_wen (ex_wen),
        .hit     (br_hit_ex)
    );
    hzd_match #(.REG_AW(REG_AW)) u_br_mem (
        .src     (dec_src1),
        .src_used(dec_branch),
        .dst     (mem_dst),
        .dst_wen (mem_wen),
        .hit     (br_hit_mem)
    );

    hzd_branch_ctl u_br (
        .dec_branch  (dec_branch),
        .dec_br_taken(dec_br_taken),
        .br_hit_ex   (br_hit_ex),
        .br_hit_mem  (br_hit_mem),
        .mem_load    (mem_load),
        .load_use    (load_use),
        .stall       (stall),
        .flush_fetch (flush_fetch),
        .br_src_fwd  (br_src_fwd)
    );

    // selects are computed in decode and travel with the instruction into execute
    always_comb begin
        state_d = state_q;
        if (stall) begin
            state_d.sel_a = SRC_REGFILE;
            state_d.sel_b = SRC_REGFILE;
        end else begin
            state_d.sel_a = pick_v[0];
            state_d.sel_b = pick_v[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{sel_a: SRC_REGFILE, sel_b: SRC_REGFILE};
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        alu_sel_a = state_q.sel_a;
        alu_sel_b = state_q.sel_b;
    end
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] dec_src1,
    input logic              dec_use1,
    input logic [REG_AW-1:0] dec_src2,
    input logic              dec_use2,
    input logic              dec_branch,
    input logic              dec_br_taken,
    input logic [REG_AW-1:0] ex_dst,
    input logic              ex_wen,
    input logic              ex_load,
    input logic [REG_AW-1:0] mem_dst,
    input logic              mem_wen,
    input logic              mem_load,
    input logic              stall,
    input logic              flush_fetch,
    input logic              br_src_fwd,
    input logic [1:0]        alu_sel_a,
    input logic [1:0]        alu_sel_b
);
    AST_NEWER_WINS_A: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dec_use1 && ex_wen && ex_dst != '0 && dec_src1 == ex_dst && !stall)
        |-> alu_sel_a == 2'b01); // R4

    AST_NO_R0_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_sel_a != 2'b00) |-> $past(dec_src1) != '0); // R5

    AST_NO_R0_FWD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_sel_b != 2'b00) |-> $past(dec_src2) != '0); // R5

    AST_LOAD_USE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_load && ex_wen && ex_dst != '0 && dec_use2 && dec_src2 == ex_dst)
        |-> stall); // R7

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stall) |-> (alu_sel_a == 2'b00 && alu_sel_b == 2'b00)); // R7

    AST_BRANCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_branch && ex_wen && ex_dst != '0 && dec_src1 == ex_dst) |-> stall); // R8

    AST_BR_FWD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        br_src_fwd |-> (dec_branch && mem_wen && !mem_load && mem_dst == dec_src1)); // R9

    AST_FLUSH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fetch |-> (dec_branch && dec_br_taken && !stall)); // R10
endmodule

bind hzd_unit hzd_unit_chk #(.REG_AW(REG_AW)) u_hzd_unit_chk (.*);

// File: tb/hzd_unit_bench.sv
module hzd_unit_bench;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] dec_src1 = '0, dec_src2 = '0, ex_dst = '0, mem_dst = '0;
    logic          dec_use1 = 0, dec_use2 = 0, dec_branch = 0, dec_br_taken = 0;
    logic          ex_wen = 0, ex_load = 0, mem_wen = 0, mem_load = 0;
    logic          stall, flush_fetch, br_src_fwd;
    logic [1:0]    alu_sel_a, alu_sel_b;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] exp_a = 2'b00;
    logic [1:0] exp_b = 2'b00;

    always #5 clk = ~clk;

    hzd_unit #(.REG_AW(AW)) u_hzd_unit (
        .clk(clk), .rst_n(rst_n),
        .dec_src1(dec_src1), .dec_use1(dec_use1),
        .dec_src2(dec_src2), .dec_use2(dec_use2),
        .dec_branch(dec_branch), .dec_br_taken(dec_br_taken),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
        .stall(stall), .flush_fetch(flush_fetch), .br_src_fwd(br_src_fwd),
        .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b)
    );

    function automatic bit dep(logic [AW-1:0] s, bit u, logic [AW-1:0] d, bit w);
        return u && w && (d != 0) && (s == d);
    endfunction

    function automatic logic [1:0] sel_for(logic [AW-1:0] s, bit u);
        if (dep(s, u, ex_dst, ex_wen))   return 2'b01; // R2 R4
        if (dep(s, u, mem_dst, mem_wen)) return 2'b10; // R3
        return 2'b00;                                  // R5 R6
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    // drive on a falling edge, check selects from the previous set first
    task automatic apply(logic [AW-1:0] s1, bit u1, logic [AW-1:0] s2, bit u2,
                         bit br, bit tk, logic [AW-1:0] ed, bit ew, bit el,
                         logic [AW-1:0] md, bit mw, bit ml);
        bit e_stall, e_fwd, e_flush, bex, bmem;
        @(negedge clk);
        chk(alu_sel_a == exp_a, "R2/R3/R4 sel_a", alu_sel_a, exp_a);
        chk(alu_sel_b == exp_b, "R2/R3/R7 sel_b", alu_sel_b, exp_b);
        dec_src1 = s1; dec_use1 = u1; dec_src2 = s2; dec_use2 = u2;
        dec_branch = br; dec_br_taken = tk;
        ex_dst = ed; ex_wen = ew; ex_load = el;
        mem_dst = md; mem_wen = mw; mem_load = ml;
        #1;
        bex  = dep(s1, br, ed, ew);
        bmem = dep(s1, br, md, mw);
        e_stall = (el && (dep(s1, u1, ed, ew) || dep(s2, u2, ed, ew)))  // R7
                  || bex || (bmem && ml);                               // R8
        e_fwd   = bmem && !ml && !bex;                                  // R9
        e_flush = br && tk && !e_stall;                                 // R10
        chk(stall == e_stall, "R7/R8 stall", stall, e_stall);
        chk(br_src_fwd == e_fwd, "R9 br_src_fwd", br_src_fwd, e_fwd);
        chk(flush_fetch == e_flush, "R10 flush_fetch", flush_fetch, e_flush);
        exp_a = e_stall ? 2'b00 : sel_for(s1, u1);
        exp_b = e_stall ? 2'b00 : sel_for(s2, u2);
    endtask

    initial begin
        #(10 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(posedge clk);
        #1;
        chk(alu_sel_a == 2'b00, "R1 reset sel_a", alu_sel_a, 0);
        chk(alu_sel_b == 2'b00, "R1 reset sel_b", alu_sel_b, 0);
        @(negedge clk);
        rst_n = 1'b1;
        //     s1 u1 s2 u2 br tk  exd ew el  memd mw ml
        apply(5, 1, 6, 1, 0, 0,  5, 1, 0,  6, 1, 0);   // R2 A, R3 B
        apply(7, 1, 7, 1, 0, 0,  7, 1, 0,  7, 1, 1);   // R4 both stages
        apply(0, 1, 0, 1, 0, 0,  0, 1, 0,  0, 1, 0);   // R5 r0
        apply(3, 0, 4, 1, 0, 0,  3, 1, 0,  4, 0, 0);   // R6 use/wen low
        apply(9, 1, 2, 1, 0, 0,  9, 1, 1,  0, 0, 0);   // R7 load-use
        apply(9, 1, 2, 1, 0, 0,  0, 0, 0,  9, 1, 1);   // R3 after bubble
        apply(0, 1, 1, 0, 0, 0,  0, 1, 1,  0, 0, 0);   // R5 load to r0
        apply(4, 1, 0, 0, 1, 1,  4, 1, 0,  0, 0, 0);   // R8 ALU in ex, no flush
        apply(4, 1, 0, 0, 1, 1,  0, 0, 0,  4, 1, 1);   // R8 load in mem
        apply(4, 1, 0, 0, 1, 1,  0, 0, 0,  4, 1, 0);   // R9 fwd + R10 flush
        apply(4, 1, 0, 0, 1, 0,  0, 0, 0,  4, 1, 0);   // R9, not taken
        apply(0, 1, 0, 0, 1, 1,  0, 1, 0,  0, 1, 0);   // R5 R10 branch on r0
        apply(1, 1, 2, 1, 0, 1,  0, 0, 0,  0, 0, 0);   // R10 taken w/o branch
        for (int k = 0; k < 3000; k++) begin
            apply($urandom % 4, $urandom % 4 != 0, $urandom % 4, $urandom % 4 != 0,
                  $urandom % 3 == 0, $urandom % 2,
                  $urandom % 4, $urandom % 4 != 0, $urandom % 3 == 0,
                  $urandom % 4, $urandom % 4 != 0, $urandom % 3 == 0);
        end
        apply(0, 0, 0, 0, 0, 0,  0, 0, 0,  0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule